// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Selector

This block decides, once per switching period, whether a synchronous buck converter should run in fixed-frequency PWM or in light-load hysteretic operation with diode emulation. A polarity comparator on the switch node is sampled at the end of each low-side conduction interval, just before the high side turns on. A positive node means the inductor current has reversed, which points to a light load. A negative node means the current is continuous. A run of identical readings in the same direction moves the block to the other mode. A sudden load step seen while in hysteretic operation forces an immediate return to PWM, and a force-continuous input keeps the converter in PWM.

The block also decides which gate requests reach the driver stage. In PWM the modulator's high-side and low-side requests pass through, with the low side held off whenever the high side is requested. In hysteretic operation a conduction pulse starts when the output reaches the lower hysteresis limit and ends at the upper limit, and both switches are off between pulses. For a fixed number of cycles after every mode change both gate requests are held low.

Top module: `mode_select_fsm`

## Requirements
- R1: After synchronous reset `mode_hyst` is 0 (PWM), `mode_stb` is 0 and the run counter is cleared. While `en` is low both gate outputs are 0.
- R2: In PWM, `mode_hyst` becomes 1 at the clock edge that samples the RUN_LEN-th (default 8) consecutive sample with `phase_pos`=1. A sample is a cycle with `smp_tick`=1.
- R3: In hysteretic mode, `mode_hyst` becomes 0 at the edge that samples the RUN_LEN-th consecutive sample with `phase_pos`=0.
- R4: A sample of the opposite polarity restarts the run from zero. Cycles with `smp_tick`=0 neither add to the run nor break it, whatever `phase_pos` shows. The run count never exceeds RUN_LEN.
- R5: In hysteretic mode, `load_drop`=1 at a clock edge returns the block to PWM at that edge, without waiting for a run.
- R6: While `force_cont`=1 the block stays in PWM or returns to it at the next edge, ignores positive samples and keeps no partial run.
- R7: `mode_stb` is high for exactly the first cycle in which a new mode value is visible, and only when the change happens with `en` high.
- R8: Starting with the strobe cycle, both gate outputs are 0 for BLANK_CYC cycles (default 3) after every mode change.
- R9: In PWM, `gate_hi` follows `pwm_hi_req`, and `gate_lo` follows `pwm_lo_req` only while `pwm_hi_req` is 0.
- R10: In hysteretic mode `gate_lo` stays 0. `gate_hi` rises in the cycle after an edge that samples `hyst_low`=1 and falls in the cycle after an edge that samples `hyst_high`=1. The upper limit wins if both are seen at once.
- R11: `en`=0 forces both gates to 0 in the same cycle. At the next edge it returns the mode to PWM and clears the run, with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| smp_tick | input | 1 | Marks the cycle in which the polarity reading is valid |
| phase_pos | input | 1 | Switch-node polarity reading, 1 = positive |
| load_drop | input | 1 | Output fell below the hysteretic regulation floor |
| force_cont | input | 1 | Inhibit hysteretic operation |
| hyst_low | input | 1 | Output at or below the lower hysteresis limit |
| hyst_high | input | 1 | Output at or above the upper hysteresis limit |
| pwm_hi_req | input | 1 | High-side request from the PWM modulator |
| pwm_lo_req | input | 1 | Low-side request from the PWM modulator |
| mode_hyst | output | 1 | Current mode, 1 = hysteretic |
| mode_stb | output | 1 | One-cycle pulse on a mode change |
| gate_hi | output | 1 | High-side gate request to the driver |
| gate_lo | output | 1 | Low-side gate request to the driver |

## Verification
The assertions assume that every input is synchronous to `clk` and settled before each rising edge, and that `smp_tick` marks single cycles, each carrying one valid polarity reading. They also assume that BLANK_CYC is at least 1 and that the hysteresis limit flags come from one comparator pair. The stimulus changes inputs only on falling edges and gives `smp_tick` as isolated one-cycle pulses between idle cycles. It never raises `load_drop` or the hysteresis limit flags outside the cases that exercise them, so each property sees only the input patterns it was written for.

// File: rtl/mode_sel_pkg.sv
`timescale 1ns/1ps
package mode_sel_pkg;

    typedef enum logic {
        MODE_PWM  = 1'b0,
        MODE_HYST = 1'b1
    } conv_mode_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_FORCE = 2'd1,
        CAUSE_STEP  = 2'd2,
        CAUSE_RUN   = 2'd3
    } xfer_cause_e;

    typedef struct packed {
        logic tick;
        logic pos;
    } pol_sample_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // A sample points toward the other mode when its polarity disagrees with the current one.
    function automatic logic toward_other(input conv_mode_e m, input logic pos);
        return (m == MODE_PWM) ? pos : !pos;
    endfunction

    function automatic conv_mode_e other_mode(input conv_mode_e m);
        return (m == MODE_PWM) ? MODE_HYST : MODE_PWM;
    endfunction

endpackage

// File: rtl/mode_run_filter.sv
`timescale 1ns/1ps
module mode_run_filter
    import mode_sel_pkg::*;
#(
    parameter int RUN_LEN = 8,
    localparam int CW = $clog2(RUN_LEN + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  conv_mode_e  mode,
    input  pol_sample_t sample,
    output logic        run_hit
);

    logic [CW-1:0] run_cnt;
    logic          toward;

    always_comb begin
        toward  = toward_other(mode, sample.pos);
        run_hit = sample.tick && toward && (run_cnt == CW'(RUN_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_cnt <= '0;
        end else if (sample.tick) begin
            if (!toward)
                run_cnt <= '0;
            else if (run_cnt != CW'(RUN_LEN))
                run_cnt <= run_cnt + 1'b1;
        end
    end

    logic chk_ok;
    always_ff @(posedge clk) begin
        if (rst) chk_ok <= 1'b0;
        else     chk_ok <= 1'b1;
    end

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        chk_ok |-> run_cnt <= CW'(RUN_LEN));

    a_r4_opposite_restarts: assert property (@(posedge clk) disable iff (rst)
        (sample.tick && !toward) |=> run_cnt == '0);

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && !sample.tick && !clear) |=> $stable(run_cnt));

endmodule

// File: rtl/mode_blank_timer.sv
`timescale 1ns/1ps
module mode_blank_timer #(
    parameter int BLANK_CYC = 3,
    localparam int BW = $clog2(BLANK_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic load,
    output logic blank_on
);

    logic [BW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !en)
            remain <= '0;
        else if (load)
            remain <= BW'(BLANK_CYC);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign blank_on = (remain != '0);

    a_r8_load_starts_blank: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> blank_on);

endmodule

// File: rtl/mode_gate_mux.sv
`timescale 1ns/1ps
module mode_gate_mux
    import mode_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  conv_mode_e mode,
    input  logic       xfer,
    input  logic       blank_on,
    input  logic       hyst_low,
    input  logic       hyst_high,
    input  gate_pair_t pwm_req,
    output gate_pair_t gate
);

    logic pulse_on;

    // Hysteretic conduction pulse: starts at the lower limit, stops at the upper limit.
    always_ff @(posedge clk) begin
        if (rst || !en || xfer || mode != MODE_HYST)
            pulse_on <= 1'b0;
        else if (hyst_high)
            pulse_on <= 1'b0;
        else if (hyst_low)
            pulse_on <= 1'b1;
    end

    always_comb begin
        gate = '0;
        if (en && !blank_on) begin
            if (mode == MODE_PWM) begin
                gate.hi = pwm_req.hi;
                gate.lo = pwm_req.lo && !pwm_req.hi;
            end else begin
                gate.hi = pulse_on;
                gate.lo = 1'b0;
            end
        end
    end

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(gate.hi && gate.lo));

    a_r10_hyst_low_side_off: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HYST) |-> !gate.lo);

    a_r8_blank_gates_off: assert property (@(posedge clk) disable iff (rst)
        blank_on |-> (gate == '0));

endmodule

// File: rtl/mode_select_fsm.sv
`timescale 1ns/1ps
module mode_select_fsm
    import mode_sel_pkg::*;
#(
    parameter int RUN_LEN   = 8,
    parameter int BLANK_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic smp_tick,
    input  logic phase_pos,
    input  logic load_drop,
    input  logic force_cont,
    input  logic hyst_low,
    input  logic hyst_high,
    input  logic pwm_hi_req,
    input  logic pwm_lo_req,
    output logic mode_hyst,
    output logic mode_stb,
    output logic gate_hi,
    output logic gate_lo
);

    conv_mode_e  mode_q, mode_d;
    xfer_cause_e cause;
    logic        xfer;
    logic        run_hit;
    logic        run_clear;
    logic        blank_on;
    logic        stb_q;
    pol_sample_t sample;
    gate_pair_t  pwm_req, gate;

    assign sample  = '{tick: smp_tick, pos: phase_pos};
    assign pwm_req = '{hi: pwm_hi_req, lo: pwm_lo_req};

    // Priority: forced continuous, then load-step escape, then a completed run.
    always_comb begin
        cause = CAUSE_NONE;
        if (en) begin
            if (force_cont) begin
                if (mode_q == MODE_HYST) cause = CAUSE_FORCE;
            end else if (mode_q == MODE_HYST && load_drop) begin
                cause = CAUSE_STEP;
            end else if (run_hit) begin
                cause = CAUSE_RUN;
            end
        end
        xfer      = (cause != CAUSE_NONE);
        run_clear = !en || force_cont || xfer;
        if (!en)
            mode_d = MODE_PWM;
        else if (xfer)
            mode_d = other_mode(mode_q);
        else
            mode_d = mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PWM;
            stb_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            stb_q  <= xfer;
        end
    end

    mode_run_filter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst     (rst),
        .clear   (run_clear),
        .mode    (mode_q),
        .sample  (sample),
        .run_hit (run_hit)
    );

    mode_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .load     (xfer),
        .blank_on (blank_on)
    );

    mode_gate_mux u_gate (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode_q),
        .xfer      (xfer),
        .blank_on  (blank_on),
        .hyst_low  (hyst_low),
        .hyst_high (hyst_high),
        .pwm_req   (pwm_req),
        .gate      (gate)
    );

    assign mode_hyst = (mode_q == MODE_HYST);
    assign mode_stb  = stb_q;
    assign gate_hi   = gate.hi;
    assign gate_lo   = gate.lo;

    logic chk_ok;
    always_ff @(posedge clk) begin
        if (rst) chk_ok <= 1'b0;
        else     chk_ok <= 1'b1;
    end

    a_r7_change_strobed: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && $past(en) && mode_hyst != $past(mode_hyst)) |-> mode_stb);

    a_r7_strobe_means_change: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && mode_stb) |-> mode_hyst != $past(mode_hyst));

    a_r6_force_holds_pwm: assert property (@(posedge clk) disable iff (rst)
        (en && force_cont) |=> !mode_hyst);

    a_r5_step_escape: assert property (@(posedge clk) disable iff (rst)
        (en && mode_hyst && load_drop) |=> (!mode_hyst && mode_stb));

    a_r11_disable_gates: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!gate_hi && !gate_lo));

    a_r11_disable_mode: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!mode_hyst && !mode_stb));

endmodule

// File: tb/mode_select_fsm_bench.sv
`timescale 1ns/1ps
module mode_select_fsm_bench;

    localparam int RUN = 8;
    localparam int BL  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, smp_tick = 0, phase_pos = 0, load_drop = 0, force_cont = 0;
    logic hyst_low = 0, hyst_high = 0, pwm_hi_req = 0, pwm_lo_req = 0;
    logic mode_hyst, mode_stb, gate_hi, gate_lo;

    always #5 clk = ~clk;

    mode_select_fsm #(.RUN_LEN(RUN), .BLANK_CYC(BL)) u_mode_select_fsm (
        .clk(clk), .rst(rst), .en(en), .smp_tick(smp_tick), .phase_pos(phase_pos),
        .load_drop(load_drop), .force_cont(force_cont), .hyst_low(hyst_low),
        .hyst_high(hyst_high), .pwm_hi_req(pwm_hi_req), .pwm_lo_req(pwm_lo_req),
        .mode_hyst(mode_hyst), .mode_stb(mode_stb), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    typedef struct {
        logic  m;
        logic  s;
        logic  h;
        logic  l;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Requirement-level model state
    bit md = 0;
    int mc = 0;
    int mb = 0;
    bit mp = 0;

    task automatic step(input logic e, tk, ps, dr, fc, hl, hh, phi, plo, input string tag);
        exp_t x;
        bit   chg, tw, np;
        @(negedge clk);
        rst = 0; en = e; smp_tick = tk; phase_pos = ps; load_drop = dr; force_cont = fc;
        hyst_low = hl; hyst_high = hh; pwm_hi_req = phi; pwm_lo_req = plo;
        chg = 0;
        if (!e) begin
            md = 0; mc = 0; mb = 0; mp = 0;
        end else begin
            tw = md ? !ps : ps;
            if (fc && md) chg = 1;
            else if (!fc && md && dr) chg = 1;
            else if (!fc && tk && tw && mc == RUN - 1) chg = 1;
            if (!md || chg) np = 0;
            else if (hh) np = 0;
            else if (hl) np = 1;
            else np = mp;
            if (fc || chg) mc = 0;
            else if (tk) mc = tw ? ((mc < RUN) ? mc + 1 : mc) : 0;
            mb = chg ? BL : ((mb > 0) ? mb - 1 : 0);
            if (chg) md = !md;
            mp = np;
        end
        x.m = md; x.s = chg; x.tag = tag;
        if (!e || mb > 0) begin
            x.h = 0; x.l = 0;
        end else if (!md) begin
            x.h = phi; x.l = plo && !phi;
        end else begin
            x.h = mp; x.l = 0;
        end
        q.push_back(x);
    endtask

    // One sample cycle followed by one idle cycle, so ticks stay isolated pulses.
    task automatic samples(input int n, input logic ps, input logic fc, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1, 1, ps, 0, fc, 0, 0, 0, 0, tag);
            step(1, 0, !ps, 0, fc, 0, 0, 0, 0, tag);
        end
    endtask

    // Monitor: compare a little after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                n_chk++;
                if (mode_hyst !== x.m || mode_stb !== x.s || gate_hi !== x.h || gate_lo !== x.l) begin
                    n_fail++;
                    $display("FAIL %s: got mode=%b stb=%b hi=%b lo=%b expected mode=%b stb=%b hi=%b lo=%b",
                             x.tag, mode_hyst, mode_stb, gate_hi, gate_lo, x.m, x.s, x.h, x.l);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state, disabled gates
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R1");
        step(0, 1, 1, 0, 0, 0, 0, 1, 1, "R1");
        // R9: PWM pass-through with overlap guard
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R4: broken run and ignored non-sample cycles
        samples(7, 1, 0, "R4");
        samples(1, 0, 0, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R4");
        samples(7, 1, 0, "R4");
        // R2: eighth positive sample flips to hysteretic
        step(1, 1, 1, 0, 0, 0, 0, 1, 0, "R2");
        // R8: blanking with requests present
        step(1, 0, 0, 0, 0, 1, 0, 1, 1, "R8");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
        // R10: hysteretic pulse control, PWM requests ignored
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, "R10");
        step(1, 0, 0, 0, 0, 1, 0, 1, 1, "R10");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        step(1, 0, 0, 0, 0, 1, 1, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R3: return to PWM after a negative run
        samples(7, 0, 0, "R3");
        samples(1, 1, 0, "R4");
        samples(8, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
        step(1, 0, 0, 0, 0, 0, 0, 1, 0, "R9");
        // R5: load-step escape
        samples(8, 1, 0, "R2");
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R6: forced continuous operation
        samples(12, 1, 1, "R6");
        samples(8, 1, 0, "R6");
        step(1, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        samples(4, 1, 1, "R6");
        samples(4, 1, 0, "R6");
        // R11: disable clears run and mode
        samples(4, 1, 0, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R11");
        samples(7, 1, 0, "R11");
        samples(1, 1, 0, "R11");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 1, 0, 1, 0, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule